// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block drives a three-and-a-half-digit static liquid-crystal panel from a digital reading. It takes three latched BCD digits, a bit that lights the leading "1", a sign bit and an overrange flag. It produces a backplane square wave and one drive line per segment. There are seven lines for each full digit, a single line that feeds both segments of the leading "1", and one line for the minus sign.

Every segment line is the exclusive-OR of its on/off state with the backplane. An unlit segment therefore moves in step with the backplane, and a lit segment moves against it. Over a whole backplane period the panel sees no net DC.

The backplane advances on a clock-enable pulse (`tick`) and toggles once every `HALF_TICKS` pulses, which gives an exact 50% duty cycle. With a 4000-count conversion and the default of 100, the backplane runs at twenty times the conversion rate. The inputs are sampled only at the clock edge where the backplane toggles, so a new reading can never flip a segment part-way through a phase.

Top module: `lcd_static_drv`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `backplane` and every segment output are 0.
- R2: `backplane` toggles at the clock edge that consumes the `HALF_TICKS`-th `tick` pulse since its previous toggle (or since reset). Cycles with `tick` low neither advance nor toggle it, so high and low phases last exactly `HALF_TICKS` ticks each.
- R3: A segment that is off is driven equal to `backplane`.
- R4: A segment that is on is driven to the inverse of `backplane`.
- R5: Digit k (k = 0 for units, 1 for tens, 2 for hundreds) is read from `digits_bcd[4k+3:4k]` and drives `seg_digits[7k+6:7k]`, with bit 0 = segment a through bit 6 = segment g. The on-patterns (bits g..a) are: 0 = 0111111, 1 = 0000110, 2 = 1011011, 3 = 1001111, 4 = 1100110, 5 = 1101101, 6 = 1111101, 7 = 0000111, 8 = 1111111, 9 = 1101111.
- R6: A digit code from 10 to 15 leaves all seven segments of that digit off.
- R7: `seg_lead` is on when `lead_one` or `over_range` is high, and off otherwise.
- R8: `seg_sign` is on exactly when `minus` is high, whether or not the reading is in overrange.
- R9: When `over_range` is high, all three full digits are off, whatever their codes.
- R10: Inputs are sampled only at the edge where `backplane` toggles. Segment outputs change only in that cycle, so input changes made mid-phase have no effect until the next toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable that advances the backplane timer |
| digits_bcd | input | 12 | BCD digits; units in bits 3:0, tens in bits 7:4, hundreds in bits 11:8 |
| lead_one | input | 1 | Request to light the leading "1" |
| minus | input | 1 | Negative-reading flag |
| over_range | input | 1 | Overrange flag |
| backplane | output | 1 | Backplane square wave |
| seg_digits | output | 21 | Segment lines a..g for units (6:0), tens (13:7) and hundreds (20:14) |
| seg_lead | output | 1 | Combined line for the leading "1" |
| seg_sign | output | 1 | Minus-sign segment line |

## Verification
The assertions take it for granted that `tick` is a one-cycle enable. They also assume every input is steady across the edge it is sampled on, and that digit codes may be any 4-bit value, including codes above 9. The stimulus drives each `tick` for exactly one clock, with gaps of zero to two idle cycles between pulses. It changes inputs only just after a falling edge. Some phases are first loaded with unrelated junk values, which are then replaced before the toggling tick; this exercises the mid-phase hold without breaking the sampling assumption.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int SEG_PER_DIGIT = 7;
  localparam int BCD_W         = 4;

  typedef logic [SEG_PER_DIGIT-1:0] seg7_t;

  // on-pattern for one digit, bit 0 = segment a ... bit 6 = segment g
  function automatic seg7_t bcd_to_seg(input logic [BCD_W-1:0] code);
    seg7_t p;
    case (code)
      4'd0: p = 7'b0111111;
      4'd1: p = 7'b0000110;
      4'd2: p = 7'b1011011;
      4'd3: p = 7'b1001111;
      4'd4: p = 7'b1100110;
      4'd5: p = 7'b1101101;
      4'd6: p = 7'b1111101;
      4'd7: p = 7'b0000111;
      4'd8: p = 7'b1111111;
      4'd9: p = 7'b1101111;
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lcd_bp_timer.sv
module lcd_bp_timer #(
  parameter int HALF_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic flip,
  output logic bp
);
  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          bp_q;

  assign flip = tick && (cnt_q == LAST);
  assign bp   = bp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else if (tick) begin
      if (flip) begin
        cnt_q <= '0;
        bp_q  <= ~bp_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  bp_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(bp_q));

  // R2
  cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(cnt_q));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_q != $past(bp_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/lcd_digit_dec.sv
module lcd_digit_dec
  import lcd_drv_pkg::*;
(
  input  logic [BCD_W-1:0] code,
  input  logic             blank,
  output seg7_t            pat
);
  assign pat = blank ? '0 : bcd_to_seg(code);

  always_comb begin
    // R9
    if (blank) blank_off_chk: assert (pat == '0);
    // R6
    if (code > 4'd9) non_bcd_off_chk: assert (pat == '0);
  end

endmodule

// File: rtl/lcd_frame_reg.sv
module lcd_frame_reg #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flip,
  input  logic         bp,
  input  logic [W-1:0] pat_in,
  output logic [W-1:0] seg_out
);
  logic [W-1:0] pat_q;
  logic [W-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q <= '0;
      seg_q <= '0;
    end else if (flip) begin
      pat_q <= pat_in;
      seg_q <= pat_in ^ {W{~bp}};
    end
  end

  assign seg_out = seg_q;

  // R10
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(flip) |-> $stable(seg_q));

  // R3
  off_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flip) |-> ((seg_q & ~pat_q) == ({W{~$past(bp)}} & ~pat_q)));

  // R4
  on_antiphase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flip) |-> ((seg_q & pat_q) == ({W{$past(bp)}} & pat_q)));

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int HALF_TICKS = 100
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick,
  input  logic [NUM_DIGITS*BCD_W-1:0]     digits_bcd,
  input  logic                            lead_one,
  input  logic                            minus,
  input  logic                            over_range,
  output logic                            backplane,
  output logic [NUM_DIGITS*SEG_PER_DIGIT-1:0] seg_digits,
  output logic                            seg_lead,
  output logic                            seg_sign
);
  localparam int DIG_W = NUM_DIGITS * SEG_PER_DIGIT;
  localparam int ALL_W = DIG_W + 2;

  logic             flip;
  logic             bp;
  logic [DIG_W-1:0] dig_pat;
  logic [ALL_W-1:0] pat_all;
  logic [ALL_W-1:0] seg_all;

  lcd_bp_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .flip (flip),
    .bp   (bp)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    lcd_digit_dec u_dec (
      .code  (digits_bcd[k*BCD_W +: BCD_W]),
      .blank (over_range),
      .pat   (dig_pat[k*SEG_PER_DIGIT +: SEG_PER_DIGIT])
    );
  end

  assign pat_all = {minus, (lead_one | over_range), dig_pat};

  lcd_frame_reg #(.W(ALL_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .flip    (flip),
    .bp      (bp),
    .pat_in  (pat_all),
    .seg_out (seg_all)
  );

  assign backplane  = bp;
  assign seg_digits = seg_all[DIG_W-1:0];
  assign seg_lead   = seg_all[DIG_W];
  assign seg_sign   = seg_all[DIG_W+1];

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    $past(rst) |-> (!backplane && seg_all == '0));

endmodule

// File: tb/lcd_static_drv_test.sv
`timescale 1ns/1ps
module lcd_static_drv_test;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [11:0] digits_bcd = '0;
  logic        lead_one = 1'b0;
  logic        minus = 1'b0;
  logic        over_range = 1'b0;
  logic        backplane;
  logic [20:0] seg_digits;
  logic        seg_lead;
  logic        seg_sign;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [22:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  lcd_static_drv #(.NUM_DIGITS(3), .HALF_TICKS(HALF)) uut (
    .clk(clk), .rst(rst), .tick(tick), .digits_bcd(digits_bcd),
    .lead_one(lead_one), .minus(minus), .over_range(over_range),
    .backplane(backplane), .seg_digits(seg_digits),
    .seg_lead(seg_lead), .seg_sign(seg_sign)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [22:0] ref_pat(input logic [11:0] d, input logic lo,
                                          input logic mn, input logic ov);
    logic [22:0] p;
    p = '0;
    for (int k = 0; k < 3; k++)
      p[k*7 +: 7] = ov ? 7'h00 : ref_seg(d[k*4 +: 4]);
    p[21] = lo | ov;
    p[22] = mn;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [22:0] act,
                       input logic [22:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic one_tick(input int gap);
    @(negedge clk); #1 tick = 1'b1;
    @(negedge clk); #1 tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_in(input logic [11:0] d, input logic lo, input logic mn,
                        input logic ov);
    @(negedge clk); #1;
    digits_bcd = d; lead_one = lo; minus = mn; over_range = ov;
  endtask

  // driver: one backplane phase ending with the given reading
  task automatic phase(input logic [11:0] d, input logic lo, input logic mn,
                       input logic ov, input string tag, input bit junk_first);
    if (junk_first) begin
      set_in(~d, ~lo, ~mn, ~ov);
      for (int i = 0; i < HALF - 1; i++) one_tick(i % 3);
      set_in(d, lo, mn, ov);
      exp_q.push_back(ref_pat(d, lo, mn, ov));
      tag_q.push_back(tag);
      one_tick(1);
    end else begin
      set_in(d, lo, mn, ov);
      exp_q.push_back(ref_pat(d, lo, mn, ov));
      tag_q.push_back(tag);
      for (int i = 0; i < HALF; i++) one_tick(i % 3);
    end
  endtask

  // monitor / scoreboard
  logic        prev_bp;
  logic [22:0] prev_seg;
  int          tick_cnt;

  always @(negedge clk) begin
    logic [22:0] act, e, onness;
    string t;
    act = {seg_sign, seg_lead, seg_digits};
    if (rst) begin
      prev_bp  <= backplane;
      prev_seg <= act;
      tick_cnt  = 0;
    end else if (!done) begin
      if (tick) tick_cnt++;
      if (backplane != prev_bp) begin
        check(tick_cnt == HALF, "R2 ticks per phase", 23'(tick_cnt), 23'(HALF));
        tick_cnt = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 toggle without expected item", act, '0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          onness = act ^ {23{backplane}};
          check((onness & ~e) == '0, "R3 off segments follow backplane", act, e ^ {23{backplane}});
          check((onness & e) == e, "R4 on segments oppose backplane", act, e ^ {23{backplane}});
          check(onness == e, t, onness, e);
        end
      end else begin
        check(act == prev_seg, "R10 outputs hold mid-phase", act, prev_seg);
      end
      prev_bp  <= backplane;
      prev_seg <= act;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(backplane == 1'b0, "R1 backplane in reset", 23'(backplane), '0);
    check({seg_sign, seg_lead, seg_digits} == '0, "R1 segments in reset",
          {seg_sign, seg_lead, seg_digits}, '0);
    #1 rst = 1'b0;
    @(negedge clk);
    check({backplane, seg_sign, seg_lead, seg_digits} == '0, "R1 after release",
          {seg_sign, seg_lead, seg_digits}, '0);

    // R5 every code in every position
    for (int i = 0; i < 10; i++)
      phase({4'((i + 7) % 10), 4'((i + 3) % 10), 4'(i)}, 1'b0, 1'b0, 1'b0,
            "R5 digit decode", 1'b0);
    // R6 non-BCD codes blank
    for (int i = 10; i < 16; i++)
      phase({4'(i), 4'd5, 4'(25 - i)}, 1'b0, 1'b0, 1'b0, "R6 non-BCD blank", 1'b0);
    // R7 leading one
    phase(12'h999, 1'b1, 1'b0, 1'b0, "R7 leading one on", 1'b0);
    phase(12'h999, 1'b0, 1'b0, 1'b0, "R7 leading one off", 1'b0);
    // R8 sign
    phase(12'h123, 1'b1, 1'b1, 1'b0, "R8 minus on", 1'b0);
    phase(12'h123, 1'b0, 1'b0, 1'b0, "R8 minus off", 1'b0);
    // R9 overrange, both signs
    phase(12'h888, 1'b0, 1'b0, 1'b1, "R9 overrange positive", 1'b0);
    phase(12'h456, 1'b0, 1'b1, 1'b1, "R9 R8 overrange negative", 1'b0);
    phase(12'hFA0, 1'b1, 1'b1, 1'b1, "R9 overrange with non-BCD", 1'b0);
    // R10 mid-phase junk is ignored
    phase(12'h307, 1'b0, 1'b1, 1'b0, "R10 late update", 1'b1);
    phase(12'h000, 1'b0, 1'b0, 1'b0, "R10 late update zero", 1'b1);
    phase(12'h642, 1'b1, 1'b0, 1'b0, "R10 late update lead", 1'b1);

    // R2 idle clocks without tick never toggle
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 all phases completed", 23'(exp_q.size()), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule